// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the control sequencer for a 32-bit load/store datapath that reuses a single ALU and a single memory over several clock cycles per instruction. It is a Moore machine: each state presents one fixed set of control levels on its output pins. Those levels steer the datapath multiplexers, the ALU operation, and the write enables of the program counter, instruction register, register file, memory and exception registers. The only inputs are the opcode field of the instruction register and the ALU overflow flag.

Every instruction starts with a fetch step and a decode step. After those two steps the path depends on the opcode. Branch and jump end after three cycles. Stores and register-to-register ALU operations end after four, and loads after five. An opcode outside the supported set, or an overflow from an ALU operation, sends the sequencer into a trap step. The trap step saves the faulting instruction's address, records a cause selection, and loads the program counter with the fixed handler vector. The datapath, register file, ALU and memory sit outside this block. The opcode must stay stable from the decode cycle until the next fetch cycle.

Top module: `mcyc_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, the outputs show the fetch vector. Reset is asynchronous, so a reset in the middle of an instruction shows the fetch vector at once.
- R2: Fetch vector: `mem_rd_en=1`, `ir_ld=1`, `pc_ld=1`, `mem_addr_sel=0` (memory address from PC), `alu_a_sel=0` (PC), `alu_b_sel=01` (constant 4), `alu_op=00` (add), `pc_src_sel=00` (ALU result).
- R3: The cycle after fetch is always the decode cycle, whatever the opcode. Decode vector: `alu_a_sel=0`, `alu_b_sel=11` (shifted sign-extended offset), `alu_op=00`, and no write enable set.
- R4: Load (opcode 0x23) runs through five cycles: fetch, decode, then address (`alu_a_sel=1`, `alu_b_sel=10` sign-extended offset, `alu_op=00`), then read (`mem_addr_sel=1`, `mem_rd_en=1`), then write-back (`rf_wr_en=1`, `rf_src_sel=1` memory data, `rf_dst_sel=0` rt field). It then returns to fetch.
- R5: Store (opcode 0x2B) runs through four cycles: fetch, decode, address (same vector as in R4), then write (`mem_addr_sel=1`, `mem_wr_en=1`). It then returns to fetch.
- R6: An ALU-format instruction (opcode 0x00) runs through four cycles: fetch, decode, execute (`alu_a_sel=1`, `alu_b_sel=00` register B, `alu_op=10` function field), then completion (`rf_wr_en=1`, `rf_dst_sel=1` rd field, `rf_src_sel=0` ALU result register). The completion cycle occurs only when `alu_ovf` is low at the edge that ends execute.
- R7: Branch-if-equal (opcode 0x04) runs through three cycles. Its third cycle drives `alu_a_sel=1`, `alu_b_sel=00`, `alu_op=01` (subtract), `pc_src_sel=01` (ALU result register) and `pc_ld_eq=1`.
- R8: Jump (opcode 0x02) runs through three cycles. Its third cycle drives `pc_ld=1` with `pc_src_sel=10` (jump target).
- R9: Any opcode other than the five above leads to a trap cycle right after decode, and then to fetch. The trap cycle drives `epc_wr=1`, `alu_a_sel=0`, `alu_b_sel=01` and `alu_op=01`, so that EPC takes PC minus 4. It also drives `cause_wr=1` with `cause_sel=0` (cause code 10), and `pc_ld=1` with `pc_src_sel=11` (vector 0x80000180).
- R10: If `alu_ovf` is high at the edge that ends execute, the next cycle is a trap cycle with the vector of R9, except that `cause_sel=1` (cause code 12). `rf_wr_en` stays low for that instruction. Fetch follows.
- R11: Every output that a state does not name is driven 0. In particular, `mem_rd_en` and `mem_wr_en` are never high together.
- R12: `alu_ovf` has no effect in any cycle except the execute cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_ovf | input | 1 | ALU signed overflow flag |
| mem_addr_sel | output | 1 | Memory address: 0 PC, 1 ALU result register |
| mem_rd_en | output | 1 | Memory read enable |
| mem_wr_en | output | 1 | Memory write enable |
| ir_ld | output | 1 | Instruction register load |
| pc_ld | output | 1 | Unconditional PC load |
| pc_ld_eq | output | 1 | PC load if ALU result is zero |
| rf_dst_sel | output | 1 | Register destination: 0 rt, 1 rd |
| rf_src_sel | output | 1 | Register write data: 0 ALU result register, 1 memory data |
| rf_wr_en | output | 1 | Register file write enable |
| alu_a_sel | output | 1 | ALU A operand: 0 PC, 1 register A |
| alu_b_sel | output | 2 | ALU B operand: 00 B, 01 four, 10 offset, 11 shifted offset |
| alu_op | output | 2 | 00 add, 01 subtract, 10 function field |
| pc_src_sel | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 trap vector |
| cause_sel | output | 1 | Cause code select: 0 code 10, 1 code 12 |
| cause_wr | output | 1 | Cause register write enable |
| epc_wr | output | 1 | Exception PC register write enable |

## Verification
Every state drives a control vector that no other state drives. A wrong state therefore shows at the ports in the very cycle it is entered, and a wrong transition shows one cycle after the edge that took it. A wrong exit from decode or execute would skip completion or trap cycles, or insert extra ones. That puts the next fetch vector one or more cycles early or late, and every later cycle of the run is then misaligned. The bench holds a reference sequence of expected states for each instruction and compares the full output vector every cycle. It also pulses the overflow flag in cycles other than execute to confirm that nothing moves.

// File: rtl/mcyc_ctrl_pkg.sv
`timescale 1ns/1ps
package mcyc_ctrl_pkg;

  localparam int OPC_W       = 6;
  localparam int N_OPC_KNOWN = 5;
  localparam int ST_W        = 4;
  localparam int CLS_W       = 3;
  localparam int SEL_W       = 2;

  localparam logic [OPC_W-1:0] OPC_ALU   = 6'h00;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OPC_W-1:0] OPC_JMP   = 6'h02;

  // index order matches op_class_e order
  localparam logic [OPC_W-1:0] KNOWN_OPC [N_OPC_KNOWN] =
    '{OPC_ALU, OPC_LOAD, OPC_STORE, OPC_BEQ, OPC_JMP};

  typedef enum logic [CLS_W-1:0] {
    CLS_ALU, CLS_LOAD, CLS_STORE, CLS_BEQ, CLS_JMP, CLS_BAD
  } op_class_e;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_LOAD_RD, ST_LOAD_WB, ST_STORE,
    ST_EXEC, ST_ALU_WB, ST_BRANCH, ST_JUMP, ST_TRAP_OPC, ST_TRAP_OVF
  } state_e;

  localparam logic [SEL_W-1:0] BSEL_REG   = 2'b00;
  localparam logic [SEL_W-1:0] BSEL_FOUR  = 2'b01;
  localparam logic [SEL_W-1:0] BSEL_IMM   = 2'b10;
  localparam logic [SEL_W-1:0] BSEL_IMMSH = 2'b11;

  localparam logic [SEL_W-1:0] AOP_ADD   = 2'b00;
  localparam logic [SEL_W-1:0] AOP_SUB   = 2'b01;
  localparam logic [SEL_W-1:0] AOP_FUNCT = 2'b10;

  localparam logic [SEL_W-1:0] PCS_ALU    = 2'b00;
  localparam logic [SEL_W-1:0] PCS_ALUREG = 2'b01;
  localparam logic [SEL_W-1:0] PCS_JUMP   = 2'b10;
  localparam logic [SEL_W-1:0] PCS_VECTOR = 2'b11;

  localparam logic CAUSE_SEL_OPC = 1'b0;
  localparam logic CAUSE_SEL_OVF = 1'b1;

  typedef struct packed {
    logic             mem_addr_sel;
    logic             mem_rd_en;
    logic             mem_wr_en;
    logic             ir_ld;
    logic             pc_ld;
    logic             pc_ld_eq;
    logic             rf_dst_sel;
    logic             rf_src_sel;
    logic             rf_wr_en;
    logic             alu_a_sel;
    logic [SEL_W-1:0] alu_b_sel;
    logic [SEL_W-1:0] alu_op;
    logic [SEL_W-1:0] pc_src_sel;
    logic             cause_sel;
    logic             cause_wr;
    logic             epc_wr;
  } ctrl_t;

endpackage

// File: rtl/mcyc_ctrl_opdec.sv
`timescale 1ns/1ps
module mcyc_ctrl_opdec
  import mcyc_ctrl_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  output op_class_e        op_class
);

  logic [N_OPC_KNOWN-1:0] hit;

  // one comparator per supported opcode
  for (genvar g = 0; g < N_OPC_KNOWN; g++) begin : g_match
    assign hit[g] = (opcode == KNOWN_OPC[g]);
  end

  always_comb begin
    op_class = CLS_BAD;
    for (int i = N_OPC_KNOWN - 1; i >= 0; i--) begin
      if (hit[i]) op_class = op_class_e'(CLS_W'(i));
    end
  end

endmodule

// File: rtl/mcyc_ctrl_seq.sv
`timescale 1ns/1ps
module mcyc_ctrl_seq
  import mcyc_ctrl_pkg::*;
(
  input  state_e    cur,
  input  op_class_e cls,
  input  logic      ovf,
  output state_e    nxt
);

  always_comb begin
    nxt = ST_FETCH;
    unique case (cur)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (cls)
          CLS_ALU:   nxt = ST_EXEC;
          CLS_LOAD:  nxt = ST_ADDR;
          CLS_STORE: nxt = ST_ADDR;
          CLS_BEQ:   nxt = ST_BRANCH;
          CLS_JMP:   nxt = ST_JUMP;
          default:   nxt = ST_TRAP_OPC;
        endcase
      end
      ST_ADDR:    nxt = (cls == CLS_LOAD) ? ST_LOAD_RD : ST_STORE;
      ST_LOAD_RD: nxt = ST_LOAD_WB;
      ST_EXEC:    nxt = ovf ? ST_TRAP_OVF : ST_ALU_WB;
      default:    nxt = ST_FETCH;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl_drive.sv
`timescale 1ns/1ps
module mcyc_ctrl_drive
  import mcyc_ctrl_pkg::*;
(
  input  state_e cur,
  output ctrl_t  ctl
);

  always_comb begin
    ctl = '0;
    unique case (cur)
      ST_FETCH: begin
        ctl.mem_rd_en  = 1'b1;
        ctl.ir_ld      = 1'b1;
        ctl.pc_ld      = 1'b1;
        ctl.alu_b_sel  = BSEL_FOUR;
        ctl.alu_op     = AOP_ADD;
        ctl.pc_src_sel = PCS_ALU;
      end
      ST_DECODE: begin
        ctl.alu_b_sel = BSEL_IMMSH;
        ctl.alu_op    = AOP_ADD;
      end
      ST_ADDR: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_IMM;
        ctl.alu_op    = AOP_ADD;
      end
      ST_LOAD_RD: begin
        ctl.mem_addr_sel = 1'b1;
        ctl.mem_rd_en    = 1'b1;
      end
      ST_LOAD_WB: begin
        ctl.rf_src_sel = 1'b1;
        ctl.rf_wr_en   = 1'b1;
      end
      ST_STORE: begin
        ctl.mem_addr_sel = 1'b1;
        ctl.mem_wr_en    = 1'b1;
      end
      ST_EXEC: begin
        ctl.alu_a_sel = 1'b1;
        ctl.alu_b_sel = BSEL_REG;
        ctl.alu_op    = AOP_FUNCT;
      end
      ST_ALU_WB: begin
        ctl.rf_dst_sel = 1'b1;
        ctl.rf_wr_en   = 1'b1;
      end
      ST_BRANCH: begin
        ctl.alu_a_sel  = 1'b1;
        ctl.alu_b_sel  = BSEL_REG;
        ctl.alu_op     = AOP_SUB;
        ctl.pc_src_sel = PCS_ALUREG;
        ctl.pc_ld_eq   = 1'b1;
      end
      ST_JUMP: begin
        ctl.pc_ld      = 1'b1;
        ctl.pc_src_sel = PCS_JUMP;
      end
      ST_TRAP_OPC, ST_TRAP_OVF: begin
        ctl.epc_wr     = 1'b1;
        ctl.alu_b_sel  = BSEL_FOUR;
        ctl.alu_op     = AOP_SUB;
        ctl.cause_wr   = 1'b1;
        ctl.cause_sel  = (cur == ST_TRAP_OVF) ? CAUSE_SEL_OVF : CAUSE_SEL_OPC;
        ctl.pc_ld      = 1'b1;
        ctl.pc_src_sel = PCS_VECTOR;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mcyc_ctrl.sv
`timescale 1ns/1ps
module mcyc_ctrl
  import mcyc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic             alu_ovf,
  output logic             mem_addr_sel,
  output logic             mem_rd_en,
  output logic             mem_wr_en,
  output logic             ir_ld,
  output logic             pc_ld,
  output logic             pc_ld_eq,
  output logic             rf_dst_sel,
  output logic             rf_src_sel,
  output logic             rf_wr_en,
  output logic             alu_a_sel,
  output logic [SEL_W-1:0] alu_b_sel,
  output logic [SEL_W-1:0] alu_op,
  output logic [SEL_W-1:0] pc_src_sel,
  output logic             cause_sel,
  output logic             cause_wr,
  output logic             epc_wr
);

  state_e    state_q;
  state_e    state_d;
  op_class_e op_cls;
  ctrl_t     ctl;

  mcyc_ctrl_opdec u_opdec (
    .opcode   (opcode),
    .op_class (op_cls)
  );

  mcyc_ctrl_seq u_seq (
    .cur (state_q),
    .cls (op_cls),
    .ovf (alu_ovf),
    .nxt (state_d)
  );

  mcyc_ctrl_drive u_drive (
    .cur (state_q),
    .ctl (ctl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_FETCH;
    else        state_q <= state_d;
  end

  assign mem_addr_sel = ctl.mem_addr_sel;
  assign mem_rd_en    = ctl.mem_rd_en;
  assign mem_wr_en    = ctl.mem_wr_en;
  assign ir_ld        = ctl.ir_ld;
  assign pc_ld        = ctl.pc_ld;
  assign pc_ld_eq     = ctl.pc_ld_eq;
  assign rf_dst_sel   = ctl.rf_dst_sel;
  assign rf_src_sel   = ctl.rf_src_sel;
  assign rf_wr_en     = ctl.rf_wr_en;
  assign alu_a_sel    = ctl.alu_a_sel;
  assign alu_b_sel    = ctl.alu_b_sel;
  assign alu_op       = ctl.alu_op;
  assign pc_src_sel   = ctl.pc_src_sel;
  assign cause_sel    = ctl.cause_sel;
  assign cause_wr     = ctl.cause_wr;
  assign epc_wr       = ctl.epc_wr;

endmodule

// File: rtl/mcyc_ctrl_chk.sv
`timescale 1ns/1ps
module mcyc_ctrl_chk
  import mcyc_ctrl_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [OPC_W-1:0] opcode,
  input logic             alu_ovf,
  input logic             mem_addr_sel,
  input logic             mem_rd_en,
  input logic             mem_wr_en,
  input logic             ir_ld,
  input logic             pc_ld,
  input logic             pc_ld_eq,
  input logic             rf_dst_sel,
  input logic             rf_src_sel,
  input logic             rf_wr_en,
  input logic             alu_a_sel,
  input logic [SEL_W-1:0] alu_b_sel,
  input logic [SEL_W-1:0] alu_op,
  input logic [SEL_W-1:0] pc_src_sel,
  input logic             cause_sel,
  input logic             cause_wr,
  input logic             epc_wr
);

  logic in_decode, in_exec, opc_known;
  assign in_decode = (alu_b_sel == BSEL_IMMSH);
  assign in_exec   = (alu_op == AOP_FUNCT);
  assign opc_known = (opcode == OPC_ALU) || (opcode == OPC_LOAD) ||
                     (opcode == OPC_STORE) || (opcode == OPC_BEQ) ||
                     (opcode == OPC_JMP);

  a_r2_fetch_vector: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |-> (mem_rd_en && !mem_addr_sel && pc_ld && !alu_a_sel &&
               alu_b_sel == BSEL_FOUR && alu_op == AOP_ADD &&
               pc_src_sel == PCS_ALU));

  a_r3_decode_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    ir_ld |=> (in_decode && !alu_a_sel && !ir_ld && !pc_ld &&
               !mem_rd_en && !rf_wr_en));

  a_r4_load_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && mem_addr_sel) |=> (rf_wr_en && rf_src_sel && !rf_dst_sel));

  a_r5_store_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> ir_ld);

  a_r6_alu_complete: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && !alu_ovf) |=> (rf_wr_en && rf_dst_sel && !rf_src_sel));

  a_r7_branch_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    pc_ld_eq |=> ir_ld);

  a_r8_jump_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_src_sel == PCS_JUMP) |=> ir_ld);

  a_r9_bad_opcode_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decode && !opc_known) |=> (epc_wr && cause_wr && !cause_sel &&
                                   pc_ld && pc_src_sel == PCS_VECTOR));

  a_r10_overflow_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (in_exec && alu_ovf) |=> (epc_wr && cause_sel && !rf_wr_en));

  a_r9_trap_then_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    epc_wr |=> ir_ld);

  a_r11_one_mem_op: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en));

endmodule

bind mcyc_ctrl mcyc_ctrl_chk chk_i (.*);

// File: tb/mcyc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mcyc_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic       alu_ovf = 1'b0;

  logic mem_addr_sel, mem_rd_en, mem_wr_en, ir_ld, pc_ld, pc_ld_eq;
  logic rf_dst_sel, rf_src_sel, rf_wr_en, alu_a_sel;
  logic [1:0] alu_b_sel, alu_op, pc_src_sel;
  logic cause_sel, cause_wr, epc_wr;

  mcyc_ctrl dut_i (.*);

  always #4 clk = ~clk;

  localparam int SF = 0, SD = 1, SA = 2, SLR = 3, SLW = 4, SST = 5,
                 SEX = 6, SRW = 7, SBR = 8, SJ = 9, STI = 10, STO = 11;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [18:0] got;
  assign got = {mem_addr_sel, mem_rd_en, mem_wr_en, ir_ld, pc_ld, pc_ld_eq,
                rf_dst_sel, rf_src_sel, rf_wr_en, alu_a_sel, alu_b_sel,
                alu_op, pc_src_sel, cause_sel, cause_wr, epc_wr};

  function automatic logic [18:0] expv(int s);
    logic ma, mr, mw, ir, pl, pe, rd, rs, rw, as_, cs, cw, ew;
    logic [1:0] bs, op, ps;
    {ma, mr, mw, ir, pl, pe, rd, rs, rw, as_, cs, cw, ew} = '0;
    bs = 2'b00; op = 2'b00; ps = 2'b00;
    case (s)
      SF:  begin mr = 1; ir = 1; pl = 1; bs = 2'b01; end
      SD:  bs = 2'b11;
      SA:  begin as_ = 1; bs = 2'b10; end
      SLR: begin ma = 1; mr = 1; end
      SLW: begin rs = 1; rw = 1; end
      SST: begin ma = 1; mw = 1; end
      SEX: begin as_ = 1; op = 2'b10; end
      SRW: begin rd = 1; rw = 1; end
      SBR: begin as_ = 1; op = 2'b01; ps = 2'b01; pe = 1; end
      SJ:  begin pl = 1; ps = 2'b10; end
      default: begin
        ew = 1; cw = 1; pl = 1; ps = 2'b11; bs = 2'b01; op = 2'b01;
        cs = (s == STO);
      end
    endcase
    return {ma, mr, mw, ir, pl, pe, rd, rs, rw, as_, bs, op, ps, cs, cw, ew};
  endfunction

  function automatic string tag_of(int s);
    case (s)
      SF: return "R2";
      SD: return "R3";
      SA, SLR, SLW: return "R4";
      SST: return "R5";
      SEX, SRW: return "R6";
      SBR: return "R7";
      SJ: return "R8";
      STI: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic check(int s, string tag);
    n_chk++;
    if (got !== expv(s)) begin
      n_fail++;
      $display("FAIL %s R11 state=%0d actual=%b expected=%b t=%0t",
               tag, s, got, expv(s), $time);
    end
  endtask

  // one instruction; starts and ends at a falling edge in a fetch cycle
  task automatic run_instr(logic [5:0] opc, logic ovf_ex, logic noise);
    int seq[$];
    string extra;
    extra = noise ? " R12" : "";
    seq.push_back(SF);
    seq.push_back(SD);
    case (opc)
      6'h23: begin seq.push_back(SA); seq.push_back(SLR); seq.push_back(SLW); end
      6'h2B: begin seq.push_back(SA); seq.push_back(SST); end
      6'h00: begin seq.push_back(SEX); seq.push_back(ovf_ex ? STO : SRW); end
      6'h04: seq.push_back(SBR);
      6'h02: seq.push_back(SJ);
      default: seq.push_back(STI);
    endcase
    foreach (seq[i]) begin
      alu_ovf = (seq[i] == SEX) ? ovf_ex : noise;
      check(seq[i], {tag_of(seq[i]), extra});
      if (seq[i] == SF) opcode = opc;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) begin
      @(negedge clk);
      check(SF, "R1 in reset");
    end
    rst_n = 1'b1;
    // R4 R5 R6 R7 R8 plain
    run_instr(6'h23, 1'b0, 1'b0);
    run_instr(6'h2B, 1'b0, 1'b0);
    run_instr(6'h00, 1'b0, 1'b0);
    run_instr(6'h04, 1'b0, 1'b0);
    run_instr(6'h02, 1'b0, 1'b0);
    // R10 overflow trap
    run_instr(6'h00, 1'b1, 1'b0);
    // R9 unsupported opcodes, including neighbours of supported ones
    run_instr(6'h3F, 1'b0, 1'b0);
    run_instr(6'h22, 1'b0, 1'b0);
    run_instr(6'h2A, 1'b0, 1'b0);
    run_instr(6'h05, 1'b0, 1'b0);
    run_instr(6'h01, 1'b0, 1'b0);
    run_instr(6'h03, 1'b0, 1'b0);
    // R12 overflow pulsed outside execute
    run_instr(6'h23, 1'b0, 1'b1);
    run_instr(6'h2B, 1'b0, 1'b1);
    run_instr(6'h00, 1'b0, 1'b1);
    run_instr(6'h04, 1'b0, 1'b1);
    run_instr(6'hFF & 6'h11, 1'b0, 1'b1);
    run_instr(6'h00, 1'b1, 1'b1);
    alu_ovf = 1'b0;
    // R1 asynchronous reset in the middle of a load
    check(SF, "R2");
    opcode = 6'h23;
    @(negedge clk);
    check(SD, "R3");
    @(negedge clk);
    check(SA, "R4");
    rst_n = 1'b0;
    #1;
    check(SF, "R1 async");
    @(negedge clk);
    check(SF, "R1 held");
    rst_n = 1'b1;
    run_instr(6'h2B, 1'b0, 1'b0);
    run_instr(6'h02, 1'b0, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1600000;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

endmodule